// File: doc/BRIEF.md
# Host Controller Interrupt Register Block

This block keeps the pending-interrupt status and the interrupt enable mask of a USB host controller. It drives one level-sensitive interrupt line toward the system. Eight internal event sources each deliver a one-cycle pulse: scheduling overrun, done-queue writeback, start of frame, resume detect, unrecoverable error, frame counter overflow, root hub change and ownership change. Each pulse latches a pending bit, and the bit stays set until software clears it.

Software reaches the block through a 32-bit register port with a two-bit register select. There are three registers. The status register is cleared by writing ones. The enable mask has two addresses: writing ones to the first sets mask bits, and writing ones to the second clears them. A master enable bit in the mask gates the whole line. Decoding of the wider register space happens outside the block, and so does the generation of the events.

Top module: `hcint_regs`

## Requirements
- R1: After a synchronous reset, status reads 0x0000_0000, the enable mask reads 0x8000_0000 (master enable only), and irq_o is low.
- R2: A pulse on evt_i[k] sets status bit P(k), where P = {0,1,2,3,4,5,6,30} for k = 0..7. The bit is visible on the first read issued after the clock edge that captured the pulse.
- R3: A write with reg_sel = 2'b00 clears every status bit written as 1 and leaves every other status bit unchanged.
- R4: When an event pulse and a clear-by-write of the same status bit fall in the same cycle, the bit remains set.
- R5: A write with reg_sel = 2'b01 ORs the written bits into the enable mask.
- R6: A write with reg_sel = 2'b10 removes the written bits from the enable mask.
- R7: A read with reg_sel = 2'b01 and a read with reg_sel = 2'b10 both return the current enable mask.
- R8: irq_o is high exactly when mask bit 31 is set and status AND mask is nonzero. It follows a register change in the cycle after the edge that made the change.
- R9: Only status bits {0..6,30} and mask bits {0..6,30,31} are stored. All other bits read 0, and writes to them have no effect.
- R10: reg_rdata shows the selected register from the clock edge that samples reg_rd, and holds that value while reg_rd is low. A read with reg_sel = 2'b11 returns 0, and a write with reg_sel = 2'b11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses, index k mapped to status bit P(k) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 00 status, 01 mask set, 10 mask clear, 11 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt line |

## Verification
A wrong status or mask bit shows up in two places: on reg_rdata at the next read, and on irq_o one edge after the faulty update, provided that bit is enabled together with the master bit. The tests set and clear single bits and then read both mask addresses, so an error in the set path, the clear path or the field mapping appears within two cycles of the write. The collision test and the partial-clear test target the two paths that share the status register. A fault in either one leaves a stale or missing bit that the next read shows.

// File: rtl/hcint_pkg.sv
package hcint_pkg;
  localparam int DW      = 32;
  localparam int EVT_N   = 8;
  localparam int SEL_W   = 2;
  localparam int MST_BIT = 31;

  localparam int EVT_POS [EVT_N] = '{0, 1, 2, 3, 4, 5, 6, 30};

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT  = 2'b00,
    SEL_ESET  = 2'b01,
    SEL_ECLR  = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;

  function automatic logic [DW-1:0] stat_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < EVT_N; k++) m[EVT_POS[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] en_mask();
    logic [DW-1:0] m;
    m = stat_mask();
    m[MST_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hcint_status.sv
module hcint_status #(
  parameter int            DW   = 32,
  parameter logic [DW-1:0] IMPL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_vec,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] clr_eff;
  logic [DW-1:0] stat_d;

  always_comb begin
    clr_eff = clr_en ? clr_vec : '0;
    // a same-cycle event outranks the software clear
    stat_d  = ((stat_q & ~clr_eff) | set_vec) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end
endmodule

// File: rtl/hcint_enable.sv
module hcint_enable #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] IMPL    = '0,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q
);
  logic [DW-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (set_en) en_d = en_d | wdata;
    if (clr_en) en_d = en_d & ~wdata;
    en_d = en_d & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= RST_VAL & IMPL;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/hcint_rdmux.sv
module hcint_rdmux #(
  parameter int DW    = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    stat,
  input  logic [DW-1:0]    en,
  output logic [DW-1:0]    rdata
);
  import hcint_pkg::*;
  logic [DW-1:0] mux;

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_STAT: mux = stat;
      SEL_ESET: mux = en;
      SEL_ECLR: mux = en;
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux;
  end
endmodule

// File: rtl/hcint_regs.sv
module hcint_regs
  import hcint_pkg::*;
#(
  parameter int DATA_W = hcint_pkg::DW,
  parameter int N_EVT  = hcint_pkg::EVT_N,
  parameter int SELW   = hcint_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SELW-1:0]   reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ST_IMPL = stat_mask();
  localparam logic [DATA_W-1:0] EN_IMPL = en_mask();
  localparam logic [DATA_W-1:0] EN_RST  = DATA_W'(1) << MST_BIT;

  logic [DATA_W-1:0] evt_vec;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] enable_q;
  logic              wr_stat, wr_set, wr_clr;

  always_comb begin
    evt_vec = '0;
    for (int k = 0; k < N_EVT; k++) evt_vec[EVT_POS[k]] = evt_i[k];
  end

  assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
  assign wr_set  = reg_wr && (reg_sel == SEL_ESET);
  assign wr_clr  = reg_wr && (reg_sel == SEL_ECLR);

  hcint_status #(.DW(DATA_W), .IMPL(ST_IMPL)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (evt_vec),
    .clr_en  (wr_stat),
    .clr_vec (reg_wdata),
    .stat_q  (status_q)
  );

  hcint_enable #(.DW(DATA_W), .IMPL(EN_IMPL), .RST_VAL(EN_RST)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .set_en (wr_set),
    .clr_en (wr_clr),
    .wdata  (reg_wdata),
    .en_q   (enable_q)
  );

  hcint_rdmux #(.DW(DATA_W), .SEL_W(SELW)) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .sel   (reg_sel),
    .stat  (status_q),
    .en    (enable_q),
    .rdata (reg_rdata)
  );

  assign irq_o = enable_q[MST_BIT] && |(status_q & enable_q);
endmodule

// File: rtl/hcint_regs_chk.sv
module hcint_regs_chk
  import hcint_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_EVT  = 8,
  parameter int SELW   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EVT-1:0]  evt_i,
  input logic              reg_wr,
  input logic [SELW-1:0]   reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] enable_q,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] ST_IMPL = stat_mask();
  localparam logic [DATA_W-1:0] EN_IMPL = en_mask();

  // R1: mask comes out of reset holding only the master bit
  p_reset_mask_r1: assert property (@(posedge clk)
    rst |=> (enable_q == (DATA_W'(1) << MST_BIT)));

  // R2 and R4: a pulse always lands, even against a clear
  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
      evt_i[k] |=> status_q[EVT_POS[k]]);
  end

  // R3
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_STAT && evt_i == '0) |=>
      (status_q == ($past(status_q) & ~$past(reg_wdata))));

  // R5
  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_ESET) |=>
      ((enable_q & $past(reg_wdata) & EN_IMPL) == ($past(reg_wdata) & EN_IMPL)));

  // R6
  p_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_ECLR) |=> ((enable_q & $past(reg_wdata)) == '0));

  // R8: the line never rises without the master bit
  p_irq_master_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> enable_q[MST_BIT]);

  // R9
  p_unimpl_r9: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~ST_IMPL) == '0) && ((enable_q & ~EN_IMPL) == '0));

  // R10: the unused select leaves both registers alone
  p_none_sel_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_NONE && evt_i == '0) |=>
      ($stable(status_q) && $stable(enable_q)));
endmodule

bind hcint_regs hcint_regs_chk #(.DATA_W(DATA_W), .N_EVT(N_EVT), .SELW(SELW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_i     (evt_i),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .irq_o     (irq_o)
);

// File: tb/hcint_regs_tb.sv
module hcint_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_i = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  int pos [8] = '{0, 1, 2, 3, 4, 5, 6, 30};

  always #10 clk = ~clk;

  hcint_regs u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'b00, v); chk("R1 status", v, 32'h0);
    rd(2'b01, v); chk("R1 mask", v, 32'h8000_0000);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      pulse(8'(1) << k);
      rd(2'b00, v); chk("R2 event map", v, 32'(1) << pos[k]);
      chk("R8 no enable no irq", {31'b0, irq_o}, 32'h0);
      wr(2'b00, 32'hFFFF_FFFF);
      rd(2'b00, v); chk("R3 full clear", v, 32'h0);
    end
  endtask

  task automatic t_partial();
    logic [31:0] v;
    pulse(8'h07);
    wr(2'b00, 32'h0000_0002);
    rd(2'b00, v); chk("R3 partial clear", v, 32'h0000_0005);
    wr(2'b00, 32'h0000_0005);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(2'b01, 32'h0000_0044);
    rd(2'b01, v); chk("R5 set", v, 32'h8000_0044);
    rd(2'b10, v); chk("R7 clear addr reads mask", v, 32'h8000_0044);
    wr(2'b01, 32'h0000_0001);
    rd(2'b01, v); chk("R5 or", v, 32'h8000_0045);
    wr(2'b10, 32'h0000_0004);
    rd(2'b10, v); chk("R6 clear", v, 32'h8000_0041);
  endtask

  task automatic t_irq();
    pulse(8'h40);
    chk("R8 irq rises", {31'b0, irq_o}, 32'h1);
    wr(2'b10, 32'h8000_0000);
    chk("R8 master gates", {31'b0, irq_o}, 32'h0);
    wr(2'b01, 32'h8000_0000);
    chk("R8 master restores", {31'b0, irq_o}, 32'h1);
    wr(2'b00, 32'h0000_0040);
    chk("R8 irq falls on clear", {31'b0, irq_o}, 32'h0);
    pulse(8'h02);
    chk("R8 disabled source", {31'b0, irq_o}, 32'h0);
    wr(2'b00, 32'h0000_0002);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    evt_i = 8'h10; reg_wr = 1'b1; reg_sel = 2'b00; reg_wdata = 32'h0000_0010;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'b00, v); chk("R4 event beats clear", v, 32'h0000_0010);
    wr(2'b00, 32'h0000_0010);
    rd(2'b00, v); chk("R4 later clear", v, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(2'b01, 32'hFFFF_FFFF);
    rd(2'b01, v); chk("R9 mask width", v, 32'hC000_007F);
    wr(2'b10, 32'hFFFF_FFFF);
    rd(2'b01, v); chk("R9 mask clear all", v, 32'h0);
    wr(2'b00, 32'hFFFF_FFFF);
    rd(2'b00, v); chk("R9 status not set by write", v, 32'h0);
    wr(2'b01, 32'h8000_0000);
  endtask

  task automatic t_none();
    logic [31:0] v;
    pulse(8'h80);
    wr(2'b11, 32'hFFFF_FFFF);
    rd(2'b11, v); chk("R10 unused select reads 0", v, 32'h0);
    rd(2'b00, v); chk("R10 unused write no status effect", v, 32'h4000_0000);
    rd(2'b01, v); chk("R10 unused write no mask effect", v, 32'h8000_0000);
    @(negedge clk);
    chk("R10 rdata holds", reg_rdata, 32'h8000_0000);
    wr(2'b00, 32'h4000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_partial();
    t_enable();
    t_irq();
    t_collide();
    t_unimpl();
    t_none();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule